// File: doc/BRIEF.md
# Register-Mapped GPIO Port with Atomic Set and Clear

This block is a GPIO port controller of configurable width (8, 16, 32 or 64 lines). It sits behind a plain single-cycle register port with an address, a write strobe with write data, and a read strobe with registered read data. Software can write the whole output latch at once. It can also raise or drop chosen lines without a read-modify-write, through a write-one-to-set register and a write-one-to-clear register. A read of the data register returns the pin levels after a two-flop synchroniser.

The line directions are held in a direction register. A build parameter picks its polarity: either a 1 means output, or a 1 means input. A third option has no direction register at all, and every line is then permanently driven from the latch as a bidirectional line. Two more build options change how register bits relate to lines. One reverses the numbering so that line n sits at register bit WIDTH-1-n. The other swaps the byte order on the bus for 16- and 32-bit ports. A further option lets software read the output latch back through the set register. The pins appear as three vectors: a driven value, an output enable and a sampled input.

Top module: `gpio_mmio_port`

## Requirements
- R1: Register selection is by `bus_addr`: 0 selects data, 1 selects set, 2 selects clear and 3 selects direction. A read is registered: `bus_rd_data` takes the selected value on the clock edge at which `bus_rd_en` is high. It holds its value while `bus_rd_en` is low, and it is 0 after reset.
- R2: A write to the data register replaces the entire output latch, which drives `pin_out`, on that clock edge.
- R3: A write to the set register sets every latch bit whose written bit is 1 and leaves every other latch bit unchanged.
- R4: A write to the clear register clears every latch bit whose written bit is 1 and leaves every other latch bit unchanged.
- R5: A read of the data register returns `pin_in` after two synchronising flops. A change on the pins is therefore not seen by a read that is issued on the same cycle as the change.
- R6: With DIR_MODE=1, a 1 in the direction register makes the line an output (`pin_oe` high). With DIR_MODE=2, a 1 makes the line an input (`pin_oe` low). In both modes a read of the direction register returns the last value written.
- R7: With DIR_MODE=0, `pin_oe` is all ones at all times. Direction writes have no effect, and a read of the direction register returns 0.
- R8: With BIT_REV=1, GPIO line n corresponds to register bit WIDTH-1-n, both for writes and for reads.
- R9: With BYTE_SWAP=1 and WIDTH of 16 or 32, bus byte k corresponds to register byte NBYTES-1-k. At widths 8 and 64 the option has no effect.
- R10: With SET_READBACK=1, a read of the set register returns the output latch. With SET_READBACK=0 it returns 0. A read of the clear register always returns 0.
- R11: After reset the output latch is 0. In modes 1 and 2 every line is an input (`pin_oe` all zero). In mode 2 the direction register therefore reads as all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select |
| bus_wr_en | input | 1 | Write strobe |
| bus_wr_data | input | WIDTH | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rd_data | output | WIDTH | Registered read data |
| pin_in | input | WIDTH | Sampled pin levels (asynchronous) |
| pin_out | output | WIDTH | Value driven on each line |
| pin_oe | output | WIDTH | Output enable for each line |

## Verification
The bench builds four copies side by side on a shared bus. The first is 16 bits wide with 1-means-output direction, byte swap and latch read-back. The second is 8 bits wide with 1-means-input direction, reversed bit numbering and no read-back. The third is 8 bits wide with no direction register and byte swap requested, where the swap must have no effect. The fourth is 64 bits wide with byte swap requested, where the swap must again have no effect. Every 8-bit write, set, clear, direction and pin pattern is swept. As a result, each polarity, both bit mappings and both byte orders are compared against arithmetic models, and the swap option is also checked at the two widths where it must be ignored.

// File: rtl/gpio_mmio_pkg.sv
package gpio_mmio_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA = 2'd0,
    REG_SET  = 2'd1,
    REG_CLR  = 2'd2,
    REG_DIR  = 2'd3
  } reg_sel_e;

  // direction register modes
  localparam int DIR_NONE    = 0;
  localparam int DIR_ONE_OUT = 1;
  localparam int DIR_ONE_IN  = 2;
endpackage

// File: rtl/gpio_lane_map.sv
module gpio_lane_map #(
  parameter int WIDTH     = 32,
  parameter bit BIT_REV   = 1'b0,
  parameter bit BYTE_SWAP = 1'b0
) (
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int  NBYTES  = WIDTH / 8;
  localparam bit  DO_SWAP = BYTE_SWAP && (WIDTH == 16 || WIDTH == 32);

  logic [WIDTH-1:0] swapped;

  // byte order stage; byte swap and bit reversal commute, so the
  // same map serves the write path and the read path
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    if (DO_SWAP) begin : g_sw
      assign swapped[8*b +: 8] = din[8*(NBYTES-1-b) +: 8];
    end else begin : g_id
      assign swapped[8*b +: 8] = din[8*b +: 8];
    end
  end

  // bit numbering stage
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (BIT_REV) begin : g_rev
      assign dout[i] = swapped[WIDTH-1-i];
    end else begin : g_fwd
      assign dout[i] = swapped[i];
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q   <= '0;
      sync_out <= '0;
    end else begin
      meta_q   <= async_in;
      sync_out <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_mmio_port.sv
module gpio_mmio_port
  import gpio_mmio_pkg::*;
#(
  parameter int WIDTH        = 32,
  parameter int DIR_MODE     = DIR_ONE_OUT,
  parameter bit BIT_REV      = 1'b0,
  parameter bit BYTE_SWAP    = 1'b0,
  parameter bit SET_READBACK = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [WIDTH-1:0]  bus_wr_data,
  input  logic              bus_rd_en,
  output logic [WIDTH-1:0]  bus_rd_data,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe
);
  localparam int W = WIDTH;

  logic [W-1:0] wr_line;
  logic [W-1:0] pin_sync;
  logic [W-1:0] dir_view;
  logic [W-1:0] rd_line;
  logic [W-1:0] rd_bus;

  gpio_lane_map #(.WIDTH(W), .BIT_REV(BIT_REV), .BYTE_SWAP(BYTE_SWAP)) u_wr_map (
    .din (bus_wr_data),
    .dout(wr_line)
  );

  gpio_in_sync #(.WIDTH(W)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_in(pin_in),
    .sync_out(pin_sync)
  );

  // output latch
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= '0;
    end else if (bus_wr_en) begin
      case (bus_addr)
        REG_DATA: pin_out <= wr_line;
        REG_SET:  pin_out <= pin_out | wr_line;
        REG_CLR:  pin_out <= pin_out & ~wr_line;
        default:  pin_out <= pin_out;
      endcase
    end
  end

  // direction
  if (DIR_MODE == DIR_NONE) begin : g_nodir
    assign pin_oe   = '1;
    assign dir_view = '0;
  end else begin : g_dir
    always_ff @(posedge clk) begin
      if (rst) begin
        pin_oe <= '0;
      end else if (bus_wr_en && bus_addr == REG_DIR) begin
        pin_oe <= (DIR_MODE == DIR_ONE_OUT) ? wr_line : ~wr_line;
      end
    end
    assign dir_view = (DIR_MODE == DIR_ONE_OUT) ? pin_oe : ~pin_oe;

    // R6
    property dir_write_p;
      @(posedge clk) disable iff (rst)
        (bus_wr_en && bus_addr == REG_DIR) |=>
          (pin_oe == ((DIR_MODE == DIR_ONE_OUT) ? $past(wr_line) : ~$past(wr_line)));
    endproperty
    // R6
    dir_write_chk: assert property (dir_write_p);

    // R11
    reset_oe_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (pin_oe == '0));
  end

  // read path
  always_comb begin
    case (bus_addr)
      REG_DATA: rd_line = pin_sync;
      REG_SET:  rd_line = SET_READBACK ? pin_out : '0;
      REG_CLR:  rd_line = '0;
      default:  rd_line = dir_view;
    endcase
  end

  gpio_lane_map #(.WIDTH(W), .BIT_REV(BIT_REV), .BYTE_SWAP(BYTE_SWAP)) u_rd_map (
    .din (rd_line),
    .dout(rd_bus)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rd_data <= '0;
    end else if (bus_rd_en) begin
      bus_rd_data <= rd_bus;
    end
  end

  // R2
  data_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_en && bus_addr == REG_DATA) |=> (pin_out == $past(wr_line)));

  // R3
  set_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_en && bus_addr == REG_SET) |=>
      (((pin_out & $past(wr_line)) == $past(wr_line)) &&
       ((pin_out & ~$past(wr_line)) == ($past(pin_out) & ~$past(wr_line)))));

  // R4
  clr_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_en && bus_addr == REG_CLR) |=>
      (((pin_out & $past(wr_line)) == '0) &&
       ((pin_out & ~$past(wr_line)) == ($past(pin_out) & ~$past(wr_line)))));

  // R1
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_en |=> $stable(bus_rd_data));

  // R11
  reset_latch_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pin_out == '0 && bus_rd_data == '0));
endmodule

// File: tb/tb_gpio_mmio_port.sv
`timescale 1ns/1ps
module tb_gpio_mmio_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  addr = '0;
  logic        we = 1'b0;
  logic        re = 1'b0;
  logic [63:0] wd = '0;
  logic [15:0] pa = '0;
  logic [7:0]  pb = '0, pc = '0;
  logic [63:0] pd = '0;
  logic [15:0] rda, outa, oea;
  logic [7:0]  rdb, outb, oeb, rdc, outc, oec;
  logic [63:0] rdd, outd, oed;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  // A: 16 bit, 1=output, byte swap, read-back
  gpio_mmio_port #(.WIDTH(16), .DIR_MODE(1), .BIT_REV(0), .BYTE_SWAP(1), .SET_READBACK(1)) dut (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr_en(we), .bus_wr_data(wd[15:0]),
    .bus_rd_en(re), .bus_rd_data(rda), .pin_in(pa), .pin_out(outa), .pin_oe(oea));
  // B: 8 bit, 1=input, reversed bits, no read-back
  gpio_mmio_port #(.WIDTH(8), .DIR_MODE(2), .BIT_REV(1), .BYTE_SWAP(0), .SET_READBACK(0)) dut_b (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr_en(we), .bus_wr_data(wd[7:0]),
    .bus_rd_en(re), .bus_rd_data(rdb), .pin_in(pb), .pin_out(outb), .pin_oe(oeb));
  // C: 8 bit, no direction register, swap requested (no effect)
  gpio_mmio_port #(.WIDTH(8), .DIR_MODE(0), .BIT_REV(0), .BYTE_SWAP(1), .SET_READBACK(1)) dut_c (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr_en(we), .bus_wr_data(wd[7:0]),
    .bus_rd_en(re), .bus_rd_data(rdc), .pin_in(pc), .pin_out(outc), .pin_oe(oec));
  // D: 64 bit, 1=output, swap requested (no effect)
  gpio_mmio_port #(.WIDTH(64), .DIR_MODE(1), .BIT_REV(0), .BYTE_SWAP(1), .SET_READBACK(1)) dut_d (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr_en(we), .bus_wr_data(wd),
    .bus_rd_en(re), .bus_rd_data(rdd), .pin_in(pd), .pin_out(outd), .pin_oe(oed));

  // models, line order
  logic [15:0] la = '0, ma = '0;
  logic [7:0]  lb = '0, mb = '0, lc = '0;
  logic [63:0] ld = '0, md = '0;

  function automatic logic [15:0] sw16(input logic [15:0] x);
    return {x[7:0], x[15:8]};
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] x);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) r[k] = x[7-k];
    return r;
  endfunction

  function automatic logic [63:0] upd(input logic [63:0] old, input logic [63:0] w,
                                      input logic [1:0] a);
    case (a)
      2'd0:    return w;
      2'd1:    return old | w;
      2'd2:    return old & ~w;
      default: return old;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [63:0] d);
    @(negedge clk);
    addr = a; wd = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    la = 16'(upd(64'(la), 64'(sw16(d[15:0])), a));
    lb = 8'(upd(64'(lb), 64'(rev8(d[7:0])), a));
    lc = 8'(upd(64'(lc), 64'(d[7:0]), a));
    ld = upd(ld, d, a);
    if (a == 2'd3) begin
      ma = sw16(d[15:0]);
      mb = ~rev8(d[7:0]);
      md = d;
    end
  endtask

  task automatic rd(input logic [1:0] a);
    @(negedge clk);
    addr = a; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic chk_outs(input string tag);
    chk({tag, " R9 A out"}, 64'(outa), 64'(la));
    chk({tag, " R8 B out"}, 64'(outb), 64'(lb));
    chk({tag, " R9 C out"}, 64'(outc), 64'(lc));
    chk({tag, " R9 D out"}, outd, ld);
    chk("R6 A oe", 64'(oea), 64'(ma));
    chk("R6 B oe", 64'(oeb), 64'(mb));
    chk("R7 C oe", 64'(oec), 64'hff);
    chk("R6 D oe", oed, md);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk_outs("R11");
    chk("R11 A rd", 64'(rda), 0);
    rd(2'd3);
    chk("R11 A dir", 64'(rda), 0);
    chk("R11 B dir", 64'(rdb), 64'hff);
    chk("R7 C dir", 64'(rdc), 0);
    chk("R11 D dir", rdd, 0);

    for (int i = 0; i < 256; i++) begin
      v = 8'(i);
      wr(2'd0, {v, v ^ 8'h5a, v + 8'd3, ~v, v, v ^ 8'hc3, ~v, v});
      chk_outs("R2");
      wr(2'd1, {v ^ 8'h0f, v, v ^ 8'h33, v ^ 8'hf0, v ^ 8'h55, v, v ^ 8'h33, v ^ 8'h81});
      chk_outs("R3");
      wr(2'd2, {v, v ^ 8'h3c, ~v, v ^ 8'h99, v, v ^ 8'h18, v ^ 8'h66, v ^ 8'h42});
      chk_outs("R4");
      rd(2'd1);
      chk("R10/R9 A set rd", 64'(rda), 64'(sw16(la)));
      chk("R10 B set rd", 64'(rdb), 0);
      chk("R10 C set rd", 64'(rdc), 64'(lc));
      chk("R10 D set rd", rdd, ld);
      @(negedge clk);
      chk("R1 A hold", 64'(rda), 64'(sw16(la)));
      rd(2'd2);
      chk("R10 A clr rd", 64'(rda), 0);
      chk("R10 D clr rd", rdd, 0);
    end

    for (int i = 0; i < 256; i++) begin
      v = 8'(i);
      wr(2'd3, {v ^ 8'h77, v, ~v, v, v ^ 8'h11, v, v ^ 8'ha5, v});
      chk_outs("R6");
      rd(2'd3);
      chk("R6/R9 A dir rd", 64'(rda), 64'(wd[15:0]));
      chk("R6/R8 B dir rd", 64'(rdb), 64'(wd[7:0]));
      chk("R7 C dir rd", 64'(rdc), 0);
      chk("R6 D dir rd", rdd, wd);
    end

    for (int i = 0; i < 256; i++) begin
      v = 8'(i);
      @(negedge clk);
      pa = {~v, v}; pb = v; pc = v ^ 8'h96; pd = {v, ~v, v ^ 8'h3c, v, 8'hff, v, ~v, v};
      @(negedge clk);
      @(negedge clk);
      rd(2'd0);
      chk("R5/R9 A pins", 64'(rda), 64'(sw16(pa)));
      chk("R5/R8 B pins", 64'(rdb), 64'(rev8(pb)));
      chk("R5 C pins", 64'(rdc), 64'(pc));
      chk("R5 D pins", rdd, pd);
    end

    // R5 synchroniser delay: a read issued at the pin change sees the old level
    @(negedge clk);
    pa = 16'h1234; addr = 2'd0; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    chk("R5 A sync delay", 64'(rda), 64'(sw16({8'h00, 8'hff})));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule